// File: doc/BRIEF.md
# Command byte decoder

This block sits on the host side of a byte-wide parallel bus. It reads only the bytes written while the 3-bit FIFO select input points at the command channel (value `100`). Each such byte carries its own type in bit 7. An address byte names a 6-bit register and says, in bit 6, whether the host wants to read it or write it. Data bytes that follow a write address each carry one 4-bit half of the register value. The upper half comes first.

Each completed pair of halves becomes one register write. The write strobe, the held register address and the assembled byte are presented together for a single clock. The write address stays held, so further pairs write the same register again; a multi-byte register is loaded this way. A read address byte raises a one-clock read request that carries its address. Any address byte discards a pair that is only half received. The downstream register file, buffers and descriptor storage are outside this block.

Top module: `cmd_decoder`

## Requirements
- R1: Bytes are taken only on a clock where `wr_en_i` is 1 and `fifo_addr_i` equals 3'b100. Any other byte causes no strobe and leaves the decoder state unchanged.
- R2: A byte with bit 7 = 1 is an address byte and a byte with bit 7 = 0 is a data byte. In an address byte, bit 6 = 1 means read, bit 6 = 0 means write, and bits 5:0 give the register address.
- R3: A read address byte makes `rd_req_o` high for exactly the next clock, with `rd_addr_o` equal to its bits 5:0. It also drops any held write address.
- R4: A write address byte raises no strobe. It holds bits 5:0 as the write address and arms the decoder for an upper nibble.
- R5: After a write address, the first data byte supplies bits 7:4 and the second supplies bits 3:0 of `reg_wr_data_o`, each from its own bits 3:0. `reg_wr_o` is high for the one clock after the second byte, with `reg_wr_addr_o` equal to the held address.
- R6: Bits 6:4 of a data byte have no effect on the assembled value.
- R7: An address byte that arrives after the upper nibble but before the lower one discards the partial nibble. The decoder then follows the new address byte alone.
- R8: After a write, the address stays held, and each further pair of data bytes produces another write to the same address.
- R9: Data bytes received with no held write address (after reset or after a read address byte) produce no write. A later lone data byte does not complete a pair with them.
- R10: After reset both strobes are low and no write address is held.
- R11: `reg_wr_o` and `rd_req_o` are never high on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write qualifier |
| fifo_addr_i | input | 3 | Channel select; 3'b100 selects the command channel |
| data_i | input | 8 | Written byte |
| reg_wr_o | output | 1 | One-clock register write strobe |
| reg_wr_addr_o | output | 6 | Register address of the write |
| reg_wr_data_o | output | 8 | Assembled register value |
| rd_req_o | output | 1 | One-clock register read request |
| rd_addr_o | output | 6 | Register address of the read request |

## Verification
Directed sequences cover several cases:
- a clean write pair, to fix nibble order;
- pairs with bits 6:4 set, which show those bits are masked;
- back-to-back pairs, which show the address is held;
- an address byte between the two halves, which shows the partial nibble is dropped rather than paired with a later byte;
- bytes on other channel selects or with the qualifier low, which the decoder must not take;
- data after a read address, which must not complete a write.

A reset inside a half-received pair checks that the nibble state is cleared. A long stretch of random bytes, mostly on the command channel, then mixes every ordering against the bench's own model.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int unsigned CMD_DW = 8;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned NIB_W  = CMD_DW / 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no write address held
    ST_HI   = 2'd1,  // address held, expecting upper nibble
    ST_LO   = 2'd2   // upper nibble held, expecting lower
  } cmd_st_e;

  typedef struct packed {
    logic              valid;
    logic              is_addr;
    logic              is_rd;
    logic [REG_AW-1:0] addr;
    logic [NIB_W-1:0]  nib;
  } cmd_byte_t;
endpackage

// File: rtl/cmd_byte_class.sv
module cmd_byte_class
  import cmd_dec_pkg::*;
#(
  parameter int unsigned         FIFO_AW = 3,
  parameter logic [FIFO_AW-1:0]  CMD_SEL = 3'b100
) (
  input  logic               wr_en_i,
  input  logic [FIFO_AW-1:0] fifo_addr_i,
  input  logic [CMD_DW-1:0]  data_i,
  output cmd_byte_t          byte_o
);
  always_comb begin
    byte_o.valid   = wr_en_i && (fifo_addr_i == CMD_SEL);
    byte_o.is_addr = data_i[CMD_DW-1];
    byte_o.is_rd   = data_i[CMD_DW-2];
    byte_o.addr    = data_i[REG_AW-1:0];
    byte_o.nib     = data_i[NIB_W-1:0];
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_addr_i,
  input  logic              is_rd_i,
  input  logic [REG_AW-1:0] addr_i,
  output cmd_st_e           state_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic              hi_load_o,
  output logic              wr_fire_o,
  output logic              rd_fire_o
);
  cmd_st_e           st_q, st_d;
  logic [REG_AW-1:0] addr_q, addr_d;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    hi_load_o = 1'b0;
    wr_fire_o = 1'b0;
    rd_fire_o = 1'b0;
    if (valid_i) begin
      if (is_addr_i) begin
        // any address byte restarts the sequence
        if (is_rd_i) begin
          rd_fire_o = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          addr_d = addr_i;
          st_d   = ST_HI;
        end
      end else begin
        unique case (st_q)
          ST_HI: begin
            hi_load_o = 1'b1;
            st_d      = ST_LO;
          end
          ST_LO: begin
            wr_fire_o = 1'b1;
            st_d      = ST_HI;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  assign state_o   = st_q;
  assign wr_addr_o = addr_q;

  // R7
  mid_pair_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO && valid_i && is_addr_i) |=> (st_q != ST_LO));

  // R4
  wr_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_addr_i && !is_rd_i) |=> (st_q == ST_HI && addr_q == $past(addr_i)));
endmodule

// File: rtl/cmd_nibble_asm.sv
module cmd_nibble_asm
  import cmd_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_load_i,
  input  logic              wr_fire_i,
  input  logic              rd_fire_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [REG_AW-1:0] addr_i,
  output logic              wr_o,
  output logic [CMD_DW-1:0] wr_data_o,
  output logic              rd_o,
  output logic [REG_AW-1:0] rd_addr_o
);
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
      rd_o      <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_o <= wr_fire_i;
      rd_o <= rd_fire_i;
      if (hi_load_i) hi_q <= nib_i;
      if (wr_fire_i) wr_data_o <= {hi_q, nib_i};
      if (rd_fire_i) rd_addr_o <= addr_i;
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o));
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int unsigned        FIFO_AW = 3,
  parameter logic [FIFO_AW-1:0] CMD_SEL = 3'b100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FIFO_AW-1:0] fifo_addr_i,
  input  logic [CMD_DW-1:0]  data_i,
  output logic               reg_wr_o,
  output logic [REG_AW-1:0]  reg_wr_addr_o,
  output logic [CMD_DW-1:0]  reg_wr_data_o,
  output logic               rd_req_o,
  output logic [REG_AW-1:0]  rd_addr_o
);
  cmd_byte_t cb;
  cmd_st_e   state;
  logic      hi_load, wr_fire, rd_fire;

  cmd_byte_class #(.FIFO_AW(FIFO_AW), .CMD_SEL(CMD_SEL)) u_class (
    .wr_en_i     (wr_en_i),
    .fifo_addr_i (fifo_addr_i),
    .data_i      (data_i),
    .byte_o      (cb)
  );

  cmd_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cb.valid),
    .is_addr_i (cb.is_addr),
    .is_rd_i   (cb.is_rd),
    .addr_i    (cb.addr),
    .state_o   (state),
    .wr_addr_o (reg_wr_addr_o),
    .hi_load_o (hi_load),
    .wr_fire_o (wr_fire),
    .rd_fire_o (rd_fire)
  );

  cmd_nibble_asm u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_load_i (hi_load),
    .wr_fire_i (wr_fire),
    .rd_fire_i (rd_fire),
    .nib_i     (cb.nib),
    .addr_i    (cb.addr),
    .wr_o      (reg_wr_o),
    .wr_data_o (reg_wr_data_o),
    .rd_o      (rd_req_o),
    .rd_addr_o (rd_addr_o)
  );

  // R1
  off_channel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && fifo_addr_i == CMD_SEL) |=> (!reg_wr_o && !rd_req_o));

  // R5
  wr_from_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(wr_en_i && fifo_addr_i == CMD_SEL && !data_i[CMD_DW-1]));

  // R3
  rd_from_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> ($past(wr_en_i && fifo_addr_i == CMD_SEL && data_i[CMD_DW-1] && data_i[CMD_DW-2])
                  && rd_addr_o == $past(data_i[REG_AW-1:0])));

  // R8
  addr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (state == ST_HI));

  // R9
  idle_data_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && cb.valid && !cb.is_addr) |=> !reg_wr_o);
endmodule

// File: tb/cmd_decoder_test.sv
module cmd_decoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] fifo_addr_i = 3'b000;
  logic [7:0] data_i = 8'h00;
  logic       reg_wr_o, rd_req_o;
  logic [5:0] reg_wr_addr_o, rd_addr_o;
  logic [7:0] reg_wr_data_o;

  cmd_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .fifo_addr_i(fifo_addr_i),
    .data_i(data_i), .reg_wr_o(reg_wr_o), .reg_wr_addr_o(reg_wr_addr_o),
    .reg_wr_data_o(reg_wr_data_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done   = 0;
  string cur_req = "R10";

  // behavioural model: 0 none held, 1 want upper, 2 want lower
  int   m_phase;
  int   m_addr, m_hi;
  bit   e_wr, e_rd;
  int   e_wr_addr, e_wr_data, e_rd_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_addr = 0; m_hi = 0;
      e_wr = 0; e_rd = 0;
    end else begin
      e_wr = 0; e_rd = 0;
      if (wr_en_i && fifo_addr_i == 3'd4) begin
        if (data_i >= 8'h80) begin
          if (data_i >= 8'hC0) begin
            e_rd = 1; e_rd_addr = data_i % 64; m_phase = 0;
          end else begin
            m_addr = data_i % 64; m_phase = 1;
          end
        end else if (m_phase == 1) begin
          m_hi = data_i % 16; m_phase = 2;
        end else if (m_phase == 2) begin
          e_wr = 1; e_wr_addr = m_addr; e_wr_data = m_hi * 16 + data_i % 16; m_phase = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done) begin
      chk(cur_req, "reg_wr_o", reg_wr_o, e_wr);
      chk(cur_req, "rd_req_o", rd_req_o, e_rd);
      chk("R11", "strobe overlap", reg_wr_o && rd_req_o, 0);
      if (e_wr) begin
        chk(cur_req, "reg_wr_addr_o", reg_wr_addr_o, e_wr_addr);
        chk(cur_req, "reg_wr_data_o", reg_wr_data_o, e_wr_data);
      end
      if (e_rd) chk(cur_req, "rd_addr_o", rd_addr_o, e_rd_addr);
    end
  end

  task automatic put(input bit en, input logic [2:0] sel, input logic [7:0] b);
    @(posedge clk_i); #2;
    wr_en_i = en; fifo_addr_i = sel; data_i = b;
  endtask

  task automatic cmd(input logic [7:0] b);
    put(1'b1, 3'd4, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 3'd4, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    idle(2);
    // R10: strobes low after reset
    chk("R10", "reset wr", reg_wr_o, 0);
    chk("R10", "reset rd", rd_req_o, 0);

    // R9: data with nothing held
    cur_req = "R9";
    cmd(8'h03); cmd(8'h04); idle(2);

    // R4 / R5 / R2: plain write, addr 5, data A3
    cur_req = "R5";
    cmd(8'h85); cmd(8'h0A); cmd(8'h03); idle(1);

    // R6: don't-care bits 6:4 set
    cur_req = "R6";
    cmd(8'h7C); cmd(8'h71); idle(1);

    // R8: further pairs to the same address
    cur_req = "R8";
    cmd(8'h02); cmd(8'h0F); cmd(8'h05); cmd(8'h0E); idle(1);

    // R1: other channel selects and qualifier low
    cur_req = "R1";
    put(1'b1, 3'd0, 8'h8A); put(1'b1, 3'd3, 8'h01); put(1'b1, 3'd5, 8'h02);
    put(1'b0, 3'd4, 8'hC1); put(1'b1, 3'd6, 8'hC2); idle(1);
    // still held address 5: a pair completes there
    cmd(8'h01); cmd(8'h02); idle(1);

    // R7: abort mid-pair
    cur_req = "R7";
    cmd(8'h81); cmd(8'h05); cmd(8'h92); cmd(8'h06); cmd(8'h07); idle(1);
    cmd(8'h09); cmd(8'hBF); cmd(8'h01); cmd(8'h02); idle(1);

    // R3 and R9: read request, then data ignored
    cur_req = "R3";
    cmd(8'hC7); idle(1); cmd(8'hFF); cmd(8'hC0); idle(1);
    cur_req = "R9";
    cmd(8'h01); cmd(8'h02); cmd(8'h03); idle(1);

    // R2: byte with bit7=1 bit6=0 is a write address
    cur_req = "R2";
    cmd(8'hAA); cmd(8'h04); cmd(8'h0B); idle(1);

    // R10: reset inside a half pair
    cur_req = "R10";
    cmd(8'h88); cmd(8'h0C);
    @(posedge clk_i); #2; wr_en_i = 0; rst_ni = 1'b0;
    @(posedge clk_i); #2; rst_ni = 1'b1;
    cmd(8'h0D); cmd(8'h0E); idle(2);

    // random mix
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      automatic logic [7:0] b = 8'($urandom);
      automatic int         r = $urandom_range(0, 9);
      if (r < 8) put(1'b1, 3'd4, (r < 2) ? b : {1'b0, b[6:0]});
      else       put(r[0], 3'($urandom), b);
    end
    idle(3);
    finish_run();
  end
endmodule